// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single 36-bit words between two independently clocked ports without going through the bulk FIFO path. Mailbox 1 carries words from port A to port B. Mailbox 2 carries words from port B to port A. Each mailbox has an active-low full flag in the domain of its writer. A write drives the flag low and locks the stored word. A later read from the other port releases the flag. While the flag is low, further writes from the writer are dropped.

Port A uses a dedicated select line to choose between a mailbox access and a FIFO access. Port B has no such line: the size code `2'b11` on its two-bit size field means a mailbox access, and any other code means a FIFO access. For FIFO accesses the block only produces qualified strobes and steers the read data. Each access is qualified by chip-select and enable both being high on the clock edge.

Each mailbox is one channel instance with two small state machines:
- The writer side has states `WR_OPEN` and `WR_HELD`. The transition *load* moves `WR_OPEN` to `WR_HELD` on an accepted write. The transition *free* moves `WR_HELD` to `WR_OPEN` when the read-release event arrives from the other domain.
- The reader side has states `RD_WAIT` and `RD_LOADED`. The transition *arrive* moves `RD_WAIT` to `RD_LOADED` when the load event has been synchronized. The transition *take* moves `RD_LOADED` to `RD_WAIT` on a read, and sends the release event back.

The events cross domains as toggles through three-flop synchronizers.

Top module: `mbx_pair`

## Requirements
- R1: While `rst_n` is low, both `mb1_full_n` and `mb2_full_n` are high, and both mailbox words read as zero.
- R2: A port A write with `a_mbox_sel` high stores `a_wdata` in mailbox 1. `mb1_full_n` is low right after that `clk_a` edge, and the stored word appears on `b_rdata` when `b_size` is `2'b11`.
- R3: A port A mailbox write while `mb1_full_n` is low is ignored, and the stored word is unchanged.
- R4: A port B read with `b_size` equal to `2'b11` after the mailbox 1 word has arrived returns `mb1_full_n` high within 16 `clk_a` cycles, and the flag stays high afterwards.
- R5: A port B write with `b_size` equal to `2'b11` stores `b_wdata` in mailbox 2, and `mb2_full_n` is low right after that `clk_b` edge.
- R6: A port B mailbox write while `mb2_full_n` is low is ignored.
- R7: A port A read with `a_mbox_sel` high returns `mb2_full_n` high within 16 `clk_b` cycles.
- R8: `a_rdata` equals the mailbox 2 word when `a_mbox_sel` is high and `a_fifo_rdata` when it is low. `b_rdata` equals the mailbox 1 word when `b_size` is `2'b11` and `b_fifo_rdata` otherwise.
- R9: A mailbox read while that mailbox's flag is high changes neither the flag nor the stored word.
- R10: An access with `a_cs`/`a_en` (or `b_cs`/`b_en`) not both high changes no flag, no stored word and no strobe.
- R11: `a_fifo_we`/`a_fifo_re` are high only for a qualified port A write or read with `a_mbox_sel` low. `b_fifo_we`/`b_fifo_re` are high only for a qualified port B write or read with `b_size` not `2'b11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs | input | 1 | Port A chip-select |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mbox_sel | input | 1 | Port A target, 1 = mailbox, 0 = FIFO |
| a_wdata | input | 36 | Port A write word |
| a_fifo_rdata | input | 36 | Word from the port A FIFO output register |
| a_rdata | output | 36 | Port A read word |
| a_fifo_we | output | 1 | Qualified port A FIFO write strobe |
| a_fifo_re | output | 1 | Qualified port A FIFO read strobe |
| mb1_full_n | output | 1 | Mailbox 1 full flag, active low, clk_a domain |
| b_cs | input | 1 | Port B chip-select |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_size | input | 2 | Port B size code, 2'b11 = mailbox |
| b_wdata | input | 36 | Port B write word |
| b_fifo_rdata | input | 36 | Word from the port B FIFO output register |
| b_rdata | output | 36 | Port B read word |
| b_fifo_we | output | 1 | Qualified port B FIFO write strobe |
| b_fifo_re | output | 1 | Qualified port B FIFO read strobe |
| mb2_full_n | output | 1 | Mailbox 2 full flag, active low, clk_b domain |

## Verification
The hardest situation to reach is a mailbox that is held while a second write and a stray read are both in flight. The stored word must survive, and the flag must move exactly once when the genuine read lands. The two clocks run at unrelated periods, 5 ns and 7 ns, so events fall at changing phase offsets. Directed steps first fill each mailbox, then hit it with blocked writes, unqualified accesses and early reads. A seeded random phase then mixes all four mailbox operations with random chip-select and enable. Each operation is followed by a settling gap long enough for both toggles to complete, so the bench model's flags and words can be compared exactly.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {WR_OPEN, WR_HELD} wr_state_t;
    typedef enum logic {RD_WAIT, RD_LOADED} rd_state_t;
    localparam int SIZE_W = 2;
    localparam logic [SIZE_W-1:0] SIZE_MBOX = 2'b11;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], tog_in};
    end

    assign pulse = sh[STAGES-1] ^ sh[STAGES-2];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    output logic         full_n,
    output logic [W-1:0] mbox_q
);
    wr_state_t wr_st, wr_nx;
    rd_state_t rd_st, rd_nx;
    logic load_tog, free_tog;
    logic load_seen, free_seen;
    logic wr_take, rd_take;

    // writer-side state machine
    always_comb begin
        wr_nx   = wr_st;
        wr_take = 1'b0;
        unique case (wr_st)
            WR_OPEN: if (wr_req) begin
                wr_nx   = WR_HELD;
                wr_take = 1'b1;
            end
            WR_HELD: if (free_seen) wr_nx = WR_OPEN;
        endcase
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wr_st <= WR_OPEN;
        else        wr_st <= wr_nx;
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            mbox_q   <= '0;
            load_tog <= 1'b0;
        end else if (wr_take) begin
            mbox_q   <= wr_data;
            load_tog <= ~load_tog;
        end
    end

    assign full_n = (wr_st == WR_OPEN);

    // reader-side state machine
    always_comb begin
        rd_nx   = rd_st;
        rd_take = 1'b0;
        unique case (rd_st)
            RD_WAIT:   if (load_seen) rd_nx = RD_LOADED;
            RD_LOADED: if (rd_req) begin
                rd_nx   = RD_WAIT;
                rd_take = 1'b1;
            end
        endcase
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rd_st <= RD_WAIT;
        else        rd_st <= rd_nx;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)       free_tog <= 1'b0;
        else if (rd_take) free_tog <= ~free_tog;
    end

    mbx_sync #(.STAGES(3)) u_load_sync (
        .clk(rd_clk), .rst_n(rst_n), .tog_in(load_tog), .pulse(load_seen)
    );

    mbx_sync #(.STAGES(3)) u_free_sync (
        .clk(wr_clk), .rst_n(rst_n), .tog_in(free_tog), .pulse(free_seen)
    );

    // R2 / R5: an accepted write drops the flag on that edge
    p_flag_drop_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_req && full_n) |=> !full_n);

    // R3 / R6: writes while held leave the word untouched
    p_hold_word_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_req && !full_n) |=> $stable(mbox_q));

    // R4 / R7: a release only ever arrives while the writer is held
    p_release_held_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        free_seen |-> !full_n);

    // R9: a read with nothing loaded sends no release
    p_no_free_idle_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_st == RD_WAIT) |=> $stable(free_tog));

    // R3: while held and no release arrives, the flag stays low
    p_stay_low_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !free_seen) |=> !full_n);
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int W = 36
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_cs,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mbox_sel,
    input  logic [W-1:0]      a_wdata,
    input  logic [W-1:0]      a_fifo_rdata,
    output logic [W-1:0]      a_rdata,
    output logic              a_fifo_we,
    output logic              a_fifo_re,
    output logic              mb1_full_n,
    input  logic              b_cs,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic [SIZE_W-1:0] b_size,
    input  logic [W-1:0]      b_wdata,
    input  logic [W-1:0]      b_fifo_rdata,
    output logic [W-1:0]      b_rdata,
    output logic              b_fifo_we,
    output logic              b_fifo_re,
    output logic              mb2_full_n
);
    logic a_go, b_go, b_mbox;
    logic [W-1:0] mb1_q, mb2_q;

    assign a_go   = a_cs & a_en;
    assign b_go   = b_cs & b_en;
    assign b_mbox = (b_size == SIZE_MBOX);

    assign a_fifo_we = a_go &  a_wr & ~a_mbox_sel;
    assign a_fifo_re = a_go & ~a_wr & ~a_mbox_sel;
    assign b_fifo_we = b_go &  b_wr & ~b_mbox;
    assign b_fifo_re = b_go & ~b_wr & ~b_mbox;

    mbx_channel #(.W(W)) u_mb1 (
        .wr_clk (clk_a),
        .rd_clk (clk_b),
        .rst_n  (rst_n),
        .wr_req (a_go & a_wr & a_mbox_sel),
        .wr_data(a_wdata),
        .rd_req (b_go & ~b_wr & b_mbox),
        .full_n (mb1_full_n),
        .mbox_q (mb1_q)
    );

    mbx_channel #(.W(W)) u_mb2 (
        .wr_clk (clk_b),
        .rd_clk (clk_a),
        .rst_n  (rst_n),
        .wr_req (b_go & b_wr & b_mbox),
        .wr_data(b_wdata),
        .rd_req (a_go & ~a_wr & a_mbox_sel),
        .full_n (mb2_full_n),
        .mbox_q (mb2_q)
    );

    assign a_rdata = a_mbox_sel ? mb2_q : a_fifo_rdata;
    assign b_rdata = b_mbox     ? mb1_q : b_fifo_rdata;

    // R11: a mailbox write on port A never raises a FIFO strobe
    p_a_strobe_r11: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_mbox_sel |-> !(a_fifo_we || a_fifo_re));
endmodule

// File: tb/sim_mbx_pair.sv
module sim_mbx_pair;
    logic clk_a = 0, clk_b = 0, rst_n = 0;
    logic a_cs = 0, a_en = 0, a_wr = 0, a_mbox_sel = 1;
    logic [35:0] a_wdata = '0, a_fifo_rdata = 36'hA_F1F0_0001, a_rdata;
    logic a_fifo_we, a_fifo_re, mb1_full_n;
    logic b_cs = 0, b_en = 0, b_wr = 0;
    logic [1:0] b_size = 2'b11;
    logic [35:0] b_wdata = '0, b_fifo_rdata = 36'hB_F1F0_0002, b_rdata;
    logic b_fifo_we, b_fifo_re, mb2_full_n;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    mbx_pair u0 (.*);

    function automatic logic [35:0] exp_rd(input logic pick_mb, input logic [35:0] mb, fifo);
        return pick_mb ? mb : fifo;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_op(input logic cs, en, wr, sel, input logic [35:0] d);
        @(negedge clk_a);
        a_cs = cs; a_en = en; a_wr = wr; a_mbox_sel = sel; a_wdata = d;
        @(posedge clk_a); #1;
        a_cs = 0; a_en = 0; a_wr = 0; a_mbox_sel = 1;
    endtask

    task automatic b_op(input logic cs, en, wr, input logic [1:0] sz, input logic [35:0] d);
        @(negedge clk_b);
        b_cs = cs; b_en = en; b_wr = wr; b_size = sz; b_wdata = d;
        @(posedge clk_b); #1;
        b_cs = 0; b_en = 0; b_wr = 0; b_size = 2'b11;
    endtask

    task automatic settle();
        repeat (12) @(posedge clk_a);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        logic [35:0] m1, m2, d;
        bit f1, f2, got;
        int op;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (4) @(posedge clk_a);
        #1;
        chk(mb1_full_n === 1'b1, "R1 mb1 flag", mb1_full_n, 1);
        chk(mb2_full_n === 1'b1, "R1 mb2 flag", mb2_full_n, 1);
        chk(a_rdata === 36'h0, "R1 mb2 word", a_rdata, 0);
        chk(b_rdata === 36'h0, "R1 mb1 word", b_rdata, 0);
        @(negedge clk_a); rst_n = 1;
        settle();

        // R11: FIFO strobes follow the selects
        @(negedge clk_a);
        a_cs = 1; a_en = 1; a_wr = 1; a_mbox_sel = 0; #1;
        chk(a_fifo_we === 1 && a_fifo_re === 0, "R11 a fifo write", {a_fifo_we, a_fifo_re}, 2'b10);
        a_wr = 0; #1;
        chk(a_fifo_re === 1 && a_fifo_we === 0, "R11 a fifo read", {a_fifo_we, a_fifo_re}, 2'b01);
        a_cs = 0; a_mbox_sel = 1; #1;
        chk(a_fifo_re === 0, "R10 a strobe needs cs", a_fifo_re, 0);
        @(negedge clk_b);
        b_cs = 1; b_en = 1; b_wr = 1; b_size = 2'b01; #1;
        chk(b_fifo_we === 1, "R11 b fifo write", b_fifo_we, 1);
        b_size = 2'b11; #1;
        chk(b_fifo_we === 0 && b_fifo_re === 0, "R11 b mailbox code", {b_fifo_we, b_fifo_re}, 0);
        b_cs = 0; b_en = 0; b_wr = 0;
        @(negedge clk_a); a_en = 0;
        // the partly-driven FIFO accesses must not touch any mailbox
        settle();
        chk(mb1_full_n === 1 && mb2_full_n === 1, "R11 fifo access no flag", {mb1_full_n, mb2_full_n}, 2'b11);

        // R10: mailbox write without enable is ignored
        a_op(1, 0, 1, 1, 36'h1_2345_6789);
        settle();
        chk(mb1_full_n === 1, "R10 a write no enable", mb1_full_n, 1);
        chk(b_rdata === 36'h0, "R10 word untouched", b_rdata, 0);

        // R2: load mailbox 1
        a_op(1, 1, 1, 1, 36'hC_AFE0_1234);
        chk(mb1_full_n === 0, "R2 flag low after write", mb1_full_n, 0);
        settle();
        chk(b_rdata === 36'hC_AFE0_1234, "R2 word at port B", b_rdata, 36'hC_AFE0_1234);

        // R3: blocked overwrite
        a_op(1, 1, 1, 1, 36'h0_DEAD_BEEF);
        settle();
        chk(b_rdata === 36'hC_AFE0_1234, "R3 word kept", b_rdata, 36'hC_AFE0_1234);
        chk(mb1_full_n === 0, "R3 flag still low", mb1_full_n, 0);

        // R10: port B read without cs does not release
        b_op(0, 1, 0, 2'b11, 0);
        settle();
        chk(mb1_full_n === 0, "R10 b read no cs", mb1_full_n, 0);

        // R8: port B FIFO view
        b_size = 2'b10; #1;
        chk(b_rdata === b_fifo_rdata, "R8 b fifo mux", b_rdata, b_fifo_rdata);
        b_size = 2'b11;

        // R4: release mailbox 1
        b_op(1, 1, 0, 2'b11, 0);
        got = 0;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk_a); #1;
            if (mb1_full_n) begin got = 1; break; end
        end
        chk(got, "R4 flag released", mb1_full_n, 1);
        settle();
        chk(mb1_full_n === 1, "R4 flag stays high", mb1_full_n, 1);

        // R9: extra read with flag high
        b_op(1, 1, 0, 2'b11, 0);
        settle();
        chk(mb1_full_n === 1 && b_rdata === 36'hC_AFE0_1234, "R9 idle read", {mb1_full_n, b_rdata}, {1'b1, 36'hC_AFE0_1234});

        // R5: load mailbox 2
        b_op(1, 1, 1, 2'b11, 36'h5_5AA5_0F0F);
        chk(mb2_full_n === 0, "R5 flag low after write", mb2_full_n, 0);
        settle();
        chk(a_rdata === 36'h5_5AA5_0F0F, "R8 mailbox view", a_rdata, 36'h5_5AA5_0F0F);
        a_mbox_sel = 0; #1;
        chk(a_rdata === a_fifo_rdata, "R8 fifo view", a_rdata, a_fifo_rdata);
        a_mbox_sel = 1;

        // R6: blocked overwrite of mailbox 2
        b_op(1, 1, 1, 2'b11, 36'h0_0000_0BAD);
        settle();
        chk(a_rdata === 36'h5_5AA5_0F0F && mb2_full_n === 0, "R6 word kept", a_rdata, 36'h5_5AA5_0F0F);

        // R7: release mailbox 2
        a_op(1, 1, 0, 1, 0);
        got = 0;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk_b); #1;
            if (mb2_full_n) begin got = 1; break; end
        end
        chk(got, "R7 flag released", mb2_full_n, 1);

        // random phase against a bench model
        settle();
        m1 = 36'hC_AFE0_1234; m2 = 36'h5_5AA5_0F0F; f1 = 0; f2 = 0;
        for (int it = 0; it < 150; it++) begin
            logic cs, en;
            op = int'($urandom_range(0, 3));
            cs = ($urandom_range(0, 7) != 0);
            en = ($urandom_range(0, 7) != 0);
            d  = {$urandom_range(0, 15), $urandom()};
            unique case (op)
                0: begin
                    a_op(cs, en, 1, 1, d);
                    if (cs && en && !f1) begin f1 = 1; m1 = d; end
                end
                1: begin
                    b_op(cs, en, 0, 2'b11, 0);
                    if (cs && en) f1 = 0;
                end
                2: begin
                    b_op(cs, en, 1, 2'b11, d);
                    if (cs && en && !f2) begin f2 = 1; m2 = d; end
                end
                default: begin
                    a_op(cs, en, 0, 1, 0);
                    if (cs && en) f2 = 0;
                end
            endcase
            settle();
            chk(mb1_full_n === !f1, "R2 R3 R4 random mb1 flag", mb1_full_n, !f1);
            chk(mb2_full_n === !f2, "R5 R6 R7 random mb2 flag", mb2_full_n, !f2);
            chk(b_rdata === exp_rd(1, m1, b_fifo_rdata), "R8 random mb1 word", b_rdata, m1);
            chk(a_rdata === exp_rd(1, m2, a_fifo_rdata), "R8 random mb2 word", a_rdata, m2);
        end

        finish_run();
    end
endmodule